// File: doc/BRIEF.md
# Timer Compare Port Set/Reset/Toggle Unit

This block watches a free-running 16-bit timer value supplied from outside and compares it with three compare registers, each loaded as two byte writes. When the timer reaches compare register 0, the low six bits of an eight-bit output port are forced high wherever a set-enable bit allows it. A hit on compare register 1 forces the enabled low six bits low. A hit on compare register 2 inverts the upper two port bits wherever a toggle enable allows it, and the same event flips two status bits held in the top of the set-enable register. The result is a small waveform generator: software picks edge times and per-pin actions, and the port pins change without any software action at the match.

Software may also write the port directly. Pins that no enable selects keep whatever value software last wrote. The timer itself is not part of this block.

Top module: `cmp_port_unit`

## Requirements
- R1: After reset the port, both enable registers and all three compare registers read zero.
- R2: On a compare-0 hit, each port bit i in 5:0 whose set-enable bit i is 1 becomes 1 one clock after the timer value is presented.
- R3: On a compare-1 hit, each port bit i in 5:0 whose reset-enable bit i is 1 becomes 0 one clock after the timer value is presented.
- R4: On a compare-2 hit, port bit 6 inverts when reset-enable bit 6 is 1, and port bit 7 inverts when reset-enable bit 7 is 1.
- R5: On a compare-2 hit, set-enable bits 7 and 6 invert under the same conditions as R4 (enable bits 7 and 6 of the reset-enable register).
- R6: A hit occurs only on the first clock on which the timer equals the compare value; while the timer holds that value, no further hit is produced.
- R7: When compare-0 and compare-1 hit in the same clock and both enables select a bit, that bit ends at 0.
- R8: A compare register takes a new value only once both its low byte and its high byte have been written, in either order; a single byte write leaves matching on the old value.
- R9: A direct port write loads all eight bits; bits whose enables are 0 keep that value through later hits, and a hit applies on top of a port write made in the same clock.
- R10: A hit requires all 16 timer bits to equal the compare register; a difference in the high byte alone gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current timer value |
| cmp_wr | input | 1 | Compare byte write strobe |
| cmp_sel | input | 2 | Compare register select (0, 1, 2) |
| cmp_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| cmp_wdata | input | 8 | Compare byte data |
| seten_wr | input | 1 | Set-enable register write strobe |
| seten_wdata | input | 8 | Set-enable write data |
| rsten_wr | input | 1 | Reset/toggle-enable register write strobe |
| rsten_wdata | input | 8 | Reset/toggle-enable write data |
| port_wr | input | 1 | Direct port write strobe |
| port_wdata | input | 8 | Direct port write data |
| port_q | output | 8 | Port output bits |
| seten_q | output | 8 | Set-enable register, bits 7:6 are toggle status |
| rsten_q | output | 8 | Reset/toggle-enable register |

## Verification
The hardest situation to reach is the mix of a half-written compare register with a timer value that equals the staged but not yet committed value, together with coincident hits on two channels. Directed steps set two compare registers to the same value to force a set/clear collision, and write only one byte of a register before presenting the timer at the staged value. The random phase draws timer values mostly from the current compare values and their neighbours, holds values for several clocks, and interleaves byte writes in random order so that commits, repeated equality and collisions occur often.

// File: rtl/cmp_port_unit.sv
module cmp_port_unit #(
  parameter int TMR_W  = 16,
  parameter int PORT_W = 8,
  parameter int SET_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TMR_W-1:0]    tmr_val,
  input  logic                cmp_wr,
  input  logic [1:0]          cmp_sel,
  input  logic                cmp_hi,
  input  logic [TMR_W/2-1:0]  cmp_wdata,
  input  logic                seten_wr,
  input  logic [PORT_W-1:0]   seten_wdata,
  input  logic                rsten_wr,
  input  logic [PORT_W-1:0]   rsten_wdata,
  input  logic                port_wr,
  input  logic [PORT_W-1:0]   port_wdata,
  output logic [PORT_W-1:0]   port_q,
  output logic [PORT_W-1:0]   seten_q,
  output logic [PORT_W-1:0]   rsten_q
);
  localparam int HALF = TMR_W / 2;
  localparam int NCMP = 3;
  localparam int TOG_W = PORT_W - SET_W;

  logic [NCMP-1:0] eq, eq_d, hit;
  logic [PORT_W-1:0] port_n, seten_n;

  for (genvar g = 0; g < NCMP; g++) begin : g_ch
    logic [HALF-1:0]  lo_s, hi_s;
    logic             lo_v, hi_v;
    logic [TMR_W-1:0] cmp_r;
    wire              sel = cmp_wr && (cmp_sel == 2'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_s <= '0; hi_s <= '0; lo_v <= 1'b0; hi_v <= 1'b0; cmp_r <= '0;
      end else if (sel) begin
        if (cmp_hi) begin
          hi_s <= cmp_wdata;
          if (lo_v) begin
            cmp_r <= {cmp_wdata, lo_s};
            lo_v  <= 1'b0;
          end else begin
            hi_v <= 1'b1;
          end
        end else begin
          lo_s <= cmp_wdata;
          if (hi_v) begin
            cmp_r <= {hi_s, cmp_wdata};
            hi_v  <= 1'b0;
          end else begin
            lo_v <= 1'b1;
          end
        end
      end
    end

    assign eq[g] = (tmr_val == cmp_r);
  end

  assign hit = eq & ~eq_d;

  always_comb begin
    port_n = port_wr ? port_wdata : port_q;
    if (hit[0]) port_n[SET_W-1:0] = port_n[SET_W-1:0] | seten_q[SET_W-1:0];
    if (hit[1]) port_n[SET_W-1:0] = port_n[SET_W-1:0] & ~rsten_q[SET_W-1:0];
    if (hit[2]) port_n[PORT_W-1:SET_W] = port_n[PORT_W-1:SET_W] ^ rsten_q[PORT_W-1:SET_W];
  end

  always_comb begin
    seten_n = seten_wr ? seten_wdata : seten_q;
    if (hit[2]) seten_n[PORT_W-1:SET_W] = seten_n[PORT_W-1:SET_W] ^ rsten_q[PORT_W-1:SET_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_d    <= '0;
      port_q  <= '0;
      seten_q <= '0;
      rsten_q <= '0;
    end else begin
      eq_d    <= eq;
      port_q  <= port_n;
      seten_q <= seten_n;
      if (rsten_wr) rsten_q <= rsten_wdata;
    end
  end

  logic [TOG_W-1:0] unused_tog;
  assign unused_tog = '0;
endmodule

// File: rtl/cmp_port_unit_chk.sv
module cmp_port_unit_chk #(
  parameter int PORT_W = 8,
  parameter int SET_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        hit,
  input logic              port_wr,
  input logic              seten_wr,
  input logic [PORT_W-1:0] port_q,
  input logic [PORT_W-1:0] seten_q,
  input logic [PORT_W-1:0] rsten_q
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && !hit[1]) |=> ((port_q[SET_W-1:0] & $past(seten_q[SET_W-1:0])) == $past(seten_q[SET_W-1:0])));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> ((port_q[SET_W-1:0] & $past(rsten_q[SET_W-1:0])) == '0));

  p_tog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[2] && !port_wr) |=> (port_q[PORT_W-1:SET_W] == ($past(port_q[PORT_W-1:SET_W]) ^ $past(rsten_q[PORT_W-1:SET_W]))));

  p_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[2] && !seten_wr) |=> (seten_q[PORT_W-1:SET_W] == ($past(seten_q[PORT_W-1:SET_W]) ^ $past(rsten_q[PORT_W-1:SET_W]))));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 3'b000 && !port_wr) |=> $stable(port_q));
endmodule

bind cmp_port_unit cmp_port_unit_chk #(.PORT_W(PORT_W), .SET_W(SET_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hit(hit), .port_wr(port_wr), .seten_wr(seten_wr),
  .port_q(port_q), .seten_q(seten_q), .rsten_q(rsten_q)
);

// File: tb/cmp_port_unit_tb.sv
module cmp_port_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tmr_val = '0;
  logic cmp_wr = 0, cmp_hi = 0, seten_wr = 0, rsten_wr = 0, port_wr = 0;
  logic [1:0] cmp_sel = '0;
  logic [7:0] cmp_wdata = '0, seten_wdata = '0, rsten_wdata = '0, port_wdata = '0;
  logic [7:0] port_q, seten_q, rsten_q;

  int checks = 0, failures = 0;

  logic [15:0] m_cmp [3];
  logic [7:0]  m_lo [3], m_hi [3];
  logic        m_lov [3], m_hiv [3];
  logic [2:0]  m_eqd;
  logic [7:0]  m_port, m_set, m_rst;

  always #2 clk = ~clk;

  cmp_port_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val),
    .cmp_wr(cmp_wr), .cmp_sel(cmp_sel), .cmp_hi(cmp_hi), .cmp_wdata(cmp_wdata),
    .seten_wr(seten_wr), .seten_wdata(seten_wdata),
    .rsten_wr(rsten_wr), .rsten_wdata(rsten_wdata),
    .port_wr(port_wr), .port_wdata(port_wdata),
    .port_q(port_q), .seten_q(seten_q), .rsten_q(rsten_q)
  );

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_cmp[c] = '0; m_lo[c] = '0; m_hi[c] = '0; m_lov[c] = 0; m_hiv[c] = 0;
    end
    m_eqd = '0; m_port = '0; m_set = '0; m_rst = '0;
  endtask

  task automatic model_step();
    logic [2:0] h;
    logic [7:0] np, ns;
    for (int c = 0; c < 3; c++) h[c] = (tmr_val == m_cmp[c]) && !m_eqd[c];
    for (int c = 0; c < 3; c++) m_eqd[c] = (tmr_val == m_cmp[c]);
    np = port_wr ? port_wdata : m_port;
    if (h[0]) np[5:0] = np[5:0] | m_set[5:0];
    if (h[1]) np[5:0] = np[5:0] & ~m_rst[5:0];
    if (h[2]) np[7:6] = np[7:6] ^ m_rst[7:6];
    ns = seten_wr ? seten_wdata : m_set;
    if (h[2]) ns[7:6] = ns[7:6] ^ m_rst[7:6];
    if (rsten_wr) m_rst = rsten_wdata;
    m_port = np; m_set = ns;
    if (cmp_wr && cmp_sel < 2'd3) begin
      if (cmp_hi) begin
        m_hi[cmp_sel] = cmp_wdata;
        if (m_lov[cmp_sel]) begin
          m_cmp[cmp_sel] = {cmp_wdata, m_lo[cmp_sel]}; m_lov[cmp_sel] = 0;
        end else m_hiv[cmp_sel] = 1;
      end else begin
        m_lo[cmp_sel] = cmp_wdata;
        if (m_hiv[cmp_sel]) begin
          m_cmp[cmp_sel] = {m_hi[cmp_sel], cmp_wdata}; m_hiv[cmp_sel] = 0;
        end else m_lov[cmp_sel] = 1;
      end
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk); #1;
    chk(tag, port_q, m_port, "port");
    chk(tag, seten_q, m_set, "seten");
    chk(tag, rsten_q, m_rst, "rsten");
    cmp_wr = 0; seten_wr = 0; rsten_wr = 0; port_wr = 0;
  endtask

  task automatic wr_cmp(int c, logic [15:0] v, string tag);
    cmp_wr = 1; cmp_sel = 2'(c); cmp_hi = 0; cmp_wdata = v[7:0]; tick(tag);
    cmp_wr = 1; cmp_sel = 2'(c); cmp_hi = 1; cmp_wdata = v[15:8]; tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    tmr_val = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    chk("R1", port_q, 8'h00, "port"); chk("R1", seten_q, 8'h00, "seten"); chk("R1", rsten_q, 8'h00, "rsten");

    // R2: set on compare 0
    wr_cmp(0, 16'h1234, "R2");
    seten_wr = 1; seten_wdata = 8'h15; tick("R2");
    tmr_val = 16'h1234; tick("R2");
    chk("R2", port_q, 8'h15, "port set");
    // R6: holding timer, port cleared by software, no re-hit
    port_wr = 1; port_wdata = 8'h00; tick("R6");
    tick("R6");
    chk("R6", port_q, 8'h00, "no rehit");

    // R10 and R3
    port_wr = 1; port_wdata = 8'h3F; tmr_val = 16'hFFFF; tick("R3");
    wr_cmp(1, 16'h5678, "R3");
    rsten_wr = 1; rsten_wdata = 8'h2A; tick("R3");
    tmr_val = 16'h5778; tick("R10");
    chk("R10", port_q, 8'h3F, "high byte differs");
    tmr_val = 16'h5678; tick("R3");
    chk("R3", port_q, 8'h15, "clear");

    // R7: coincident set and clear
    wr_cmp(0, 16'h0AAA, "R7");
    wr_cmp(1, 16'h0AAA, "R7");
    port_wr = 1; port_wdata = 8'h00; seten_wr = 1; seten_wdata = 8'h3F; tick("R7");
    rsten_wr = 1; rsten_wdata = 8'h03; tick("R7");
    tmr_val = 16'h0AAA; tick("R7");
    chk("R7", port_q, 8'h3C, "clear wins");

    // R4 / R5: toggle and status
    tmr_val = 16'hFFFF;
    wr_cmp(2, 16'h0100, "R4");
    rsten_wr = 1; rsten_wdata = 8'h40; tick("R4");
    tmr_val = 16'h0100; tick("R4");
    chk("R4", port_q & 8'hC0, 8'h40, "toggle bit6");
    chk("R5", seten_q & 8'hC0, 8'h40, "status bit6");
    tmr_val = 16'h0101; tick("R4");
    rsten_wr = 1; rsten_wdata = 8'hC0; tick("R4");
    tmr_val = 16'h0100; tick("R4");
    chk("R4", port_q & 8'hC0, 8'h80, "toggle both");
    chk("R5", seten_q & 8'hC0, 8'h80, "status both");

    // R8: one byte only leaves old value active
    tmr_val = 16'hFFFF;
    port_wr = 1; port_wdata = 8'h00; seten_wr = 1; seten_wdata = 8'h01; rsten_wr = 1; rsten_wdata = 8'h00; tick("R8");
    cmp_wr = 1; cmp_sel = 2'd0; cmp_hi = 0; cmp_wdata = 8'h22; tick("R8");
    tmr_val = 16'h0A22; tick("R8");
    chk("R8", port_q, 8'h00, "half write");
    tmr_val = 16'hFFFF; tick("R8");
    cmp_wr = 1; cmp_sel = 2'd0; cmp_hi = 1; cmp_wdata = 8'h0B; tick("R8");
    tmr_val = 16'h0B22; tick("R8");
    chk("R8", port_q, 8'h01, "full write");

    // R9: no enables keep software value
    seten_wr = 1; seten_wdata = 8'h00; rsten_wr = 1; rsten_wdata = 8'h00; tick("R9");
    port_wr = 1; port_wdata = 8'hA5; tick("R9");
    tmr_val = 16'h0AAA; tick("R9");
    tmr_val = 16'h0100; tick("R9");
    tmr_val = 16'h0B22; tick("R9");
    chk("R9", port_q, 8'hA5, "hold");

    // Random: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 6) tmr_val = m_cmp[$urandom_range(0, 2)] ^ (($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0);
      else if (sel < 8) tmr_val = tmr_val;
      else tmr_val = 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        cmp_wr = 1; cmp_sel = 2'($urandom_range(0, 2)); cmp_hi = 1'($urandom); cmp_wdata = ($urandom_range(0, 1) == 0) ? tmr_val[7:0] : 8'($urandom);
      end
      if ($urandom_range(0, 15) == 0) begin seten_wr = 1; seten_wdata = 8'($urandom); end
      if ($urandom_range(0, 15) == 0) begin rsten_wr = 1; rsten_wdata = 8'($urandom); end
      if ($urandom_range(0, 15) == 0) begin port_wr = 1; port_wdata = 8'($urandom); end
      tick("RAND R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule